// File: doc/BRIEF.md
# ADC Scan Sequencer

This block is the digital controller that sits beside a four-input analog-to-digital converter core. Software programs a control word with a conversion mode, a channel field, an interrupt enable and a start bit. The sequencer then drives the converter core through a one-cycle start pulse and waits for the core to answer with a done strobe and a 10-bit sample. Each sample is stored in a data register that belongs to its channel.

Single mode converts exactly one channel. Multi mode always begins at channel 0 and steps upward to the channel named in the channel field. The next conversion is issued in the cycle right after the previous one returns. When a pass completes, the block sets an end flag, clears the start bit by itself, and raises an interrupt if interrupts are enabled. If software clears the start bit in the middle of a pass, the pass stops. The result of the conversion that was in flight is thrown away, and the next start begins again from the first channel.

Registers are reached over a plain register bus. Writes are synchronous and reads are combinational. Address 0 is the control word. Addresses 4 to 7 hold the results for channels 0 to 3.

Top module: `adc_scan_top`

## Requirements
- R1: After reset, the control word reads 0, all four data registers read 0, and `irq` and `conv_start` are low.
- R2: When the mode field (control bits [5:4]) holds any value other than 2'b10, a start runs single mode. Exactly one conversion is made, on the channel given in control bits [1:0], and the other data registers keep their values.
- R3: When the mode field is 2'b10, a start converts channels 0, 1, … up to the value in control bits [1:0]. Each channel is converted once, in ascending order.
- R4: `conv_start` is high for one cycle, with the channel on `conv_ch`. The sample is taken in the cycle where `conv_done` is high. Within a pass, the next `conv_start` comes in the cycle right after that `conv_done`.
- R5: The result of channel k is stored at address 4+k in bits [9:0]. Bits [15:10] read as 0.
- R6: When the last conversion of a pass is accepted, the end flag (control bit 15) is set, the start bit (control bit 13) returns to 0, and the sequencer goes idle.
- R7: `irq` is high exactly when both the end flag and the interrupt enable (control bit 14) are 1.
- R8: Writing the control word with bit 15 = 0 clears the end flag. Writing 1 to bit 15 never sets it.
- R9: Writing 0 to the start bit during a pass stops it. No further `conv_start` is issued, a `conv_done` that arrives later is discarded, and the end flag stays 0. The next start begins from the pass's first channel.
- R10: The mode, channel and interrupt-enable fields read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address: 0 control, 4..7 channel data |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data at reg_addr |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_ch | output | 2 | Channel to convert, valid with conv_start |
| conv_done | input | 1 | Converter core strobe: conv_data is valid |
| conv_data | input | 10 | Sample from the converter core |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check the handshake rules on every cycle. They check that the start pulse lasts one cycle, and that multi mode opens on channel 0 while single mode opens on the programmed channel. They check that each accepted result, other than the last, is followed at once by a start for the next channel. They also check that results are written only while the start bit is set, and that completing a pass sets the end flag and clears the start bit. Other behaviours only show up in the bench's scenarios: the full channel order of a pass, which data register each sample lands in, the discarding of a late result after an abort, the restart from channel 0, and the write-0/write-1 rules for the end flag.

// File: rtl/adc_scan_pkg.sv
// Shared constants for the ADC scan sequencer: sizes, control-word bit
// positions, the multi-mode code and the sequencer state type.
package adc_scan_pkg;
    localparam int NUM_CH    = 4;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int SAMPLE_W  = 10;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 3;
    localparam int MODE_W    = 2;

    localparam int BIT_DONE  = 15;
    localparam int BIT_IE    = 14;
    localparam int BIT_START = 13;
    localparam int MODE_LSB  = 4;

    localparam logic [MODE_W-1:0] MODE_MULTI = 2'b10;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_scan_csr.sv
// Register block of the scan sequencer. Holds the control word (mode,
// channel field, interrupt enable, start bit, end flag) and one result
// register per channel. Assumes the sequencer raises res_we_i only while
// the start bit is set, and raises pass_done_i together with the last
// accepted result of a pass. A software write to the start bit takes
// priority over the hardware clear at the end of a pass.
module adc_scan_csr
    import adc_scan_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int CHW   = CH_W,
    parameter int SMPW  = SAMPLE_W,
    parameter int RW    = REG_W,
    parameter int AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    output logic              start_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [CHW-1:0]    chsel_o,
    output logic              irq_o,
    input  logic              pass_done_i,
    input  logic              res_we_i,
    input  logic [CHW-1:0]    res_ch_i,
    input  logic [SMPW-1:0]   res_data_i
);
    localparam logic [AW-1:0] CTRL_ADDR = '0;

    logic              start_q, done_q, ie_q;
    logic [MODE_W-1:0] mode_q;
    logic [CHW-1:0]    chsel_q;
    logic [SMPW-1:0]   data_q [NCH];
    logic              ctrl_wr;
    logic              unused_wdata;

    assign ctrl_wr      = reg_wr && (reg_addr == CTRL_ADDR);
    assign unused_wdata = ^reg_wdata;

    // Control fields: software writes, hardware clears start at pass end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            ie_q    <= 1'b0;
            mode_q  <= '0;
            chsel_q <= '0;
        end else if (ctrl_wr) begin
            start_q <= reg_wdata[BIT_START];
            ie_q    <= reg_wdata[BIT_IE];
            mode_q  <= reg_wdata[MODE_LSB +: MODE_W];
            chsel_q <= reg_wdata[CHW-1:0];
        end else if (pass_done_i) begin
            start_q <= 1'b0;
        end
    end

    // End flag: set by hardware, cleared only by a software write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (pass_done_i)
            done_q <= 1'b1;
        else if (ctrl_wr && !reg_wdata[BIT_DONE])
            done_q <= 1'b0;
    end

    // One result register per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_data
        // Capture the accepted sample addressed to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[g] <= '0;
            else if (res_we_i && (res_ch_i == CHW'(g)))
                data_q[g] <= res_data_i;
        end
    end

    // Combinational read mux over the control word and the result registers.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata[BIT_DONE]            = done_q;
            reg_rdata[BIT_IE]              = ie_q;
            reg_rdata[BIT_START]           = start_q;
            reg_rdata[MODE_LSB +: MODE_W]  = mode_q;
            reg_rdata[CHW-1:0]             = chsel_q;
        end else if (reg_addr[AW-1]) begin
            reg_rdata[SMPW-1:0] = data_q[reg_addr[CHW-1:0]];
        end
    end

    assign start_o = start_q;
    assign mode_o  = mode_q;
    assign chsel_o = chsel_q;
    assign irq_o   = done_q & ie_q;

    assert_done_after_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done_i |=> done_q);
    assert_start_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_done_i && !ctrl_wr) |=> !start_q);
    assert_result_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_we_i |-> start_q);
    assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !reg_wdata[BIT_DONE] && !pass_done_i) |=> !done_q);
endmodule

// File: rtl/adc_scan_seq.sv
// Channel walker of the scan sequencer. On a start it picks the first
// channel (0 in multi mode, the programmed channel otherwise) and the last
// channel (the programmed channel), then issues one conversion per channel.
// Assumes the converter core answers each conv_start_o with one conv_done_i.
// A low start_i at any point in a pass returns it to idle and discards
// any sample that arrives afterwards.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CHW  = CH_W,
    parameter int SMPW = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CHW-1:0]    chsel_i,
    output logic              conv_start_o,
    output logic [CHW-1:0]    conv_ch_o,
    input  logic              conv_done_i,
    input  logic [SMPW-1:0]   conv_data_i,
    output logic              res_we_o,
    output logic [CHW-1:0]    res_ch_o,
    output logic [SMPW-1:0]   res_data_o,
    output logic              pass_done_o
);
    seq_state_e     state_q;
    logic [CHW-1:0] cur_q, last_q;
    logic           accept;

    // Walk the channels of a pass and drop back to idle on abort or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start_i) begin
                    cur_q   <= (mode_i == MODE_MULTI) ? '0 : chsel_i;
                    last_q  <= chsel_i;
                    state_q <= SEQ_ISSUE;
                end
                SEQ_ISSUE: state_q <= start_i ? SEQ_WAIT : SEQ_IDLE;
                SEQ_WAIT: begin
                    if (!start_i)
                        state_q <= SEQ_IDLE;
                    else if (conv_done_i) begin
                        if (cur_q == last_q)
                            state_q <= SEQ_IDLE;
                        else begin
                            cur_q   <= cur_q + 1'b1;
                            state_q <= SEQ_ISSUE;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Core handshake and result hand-off to the register block.
    always_comb begin
        accept       = (state_q == SEQ_WAIT) && start_i && conv_done_i;
        conv_start_o = (state_q == SEQ_ISSUE) && start_i;
        conv_ch_o    = cur_q;
        res_we_o     = accept;
        res_ch_o     = cur_q;
        res_data_o   = conv_data_i;
        pass_done_o  = accept && (cur_q == last_q);
    end

    assert_conv_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);
    assert_multi_first_ch0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && start_i && mode_i == MODE_MULTI) |=> (conv_ch_o == '0));
    assert_single_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && start_i && mode_i != MODE_MULTI) |=> (conv_ch_o == $past(chsel_i)));
    assert_next_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we_o && !pass_done_o) |=>
            ((conv_start_o || !start_i) && conv_ch_o == $past(res_ch_o) + CHW'(1)));
endmodule

// File: rtl/adc_scan_top.sv
// Top of the ADC scan sequencer: the register block and the channel walker
// joined together. Assumes a converter core that answers every start pulse
// with exactly one done strobe, after any latency of one cycle or more.
module adc_scan_top
    import adc_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                conv_start,
    output logic [CH_W-1:0]     conv_ch,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic                irq
);
    logic              start_w, pass_done_w, res_we_w;
    logic [MODE_W-1:0] mode_w;
    logic [CH_W-1:0]   chsel_w, res_ch_w;
    logic [SAMPLE_W-1:0] res_data_w;

    adc_scan_csr u_csr (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .start_o(start_w), .mode_o(mode_w), .chsel_o(chsel_w), .irq_o(irq),
        .pass_done_i(pass_done_w), .res_we_i(res_we_w), .res_ch_i(res_ch_w), .res_data_i(res_data_w)
    );

    adc_scan_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_w), .mode_i(mode_w), .chsel_i(chsel_w),
        .conv_start_o(conv_start), .conv_ch_o(conv_ch),
        .conv_done_i(conv_done), .conv_data_i(conv_data),
        .res_we_o(res_we_w), .res_ch_o(res_ch_w), .res_data_o(res_data_w),
        .pass_done_o(pass_done_w)
    );
endmodule

// File: tb/adc_scan_top_tb.sv
// Bench for the ADC scan sequencer: a behavioural converter core with a
// programmable latency, directed corner cases and seeded random passes.
module adc_scan_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        conv_start;
    logic [1:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic        irq;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    // converter core model state
    int         lat_cfg = 1, cnt = 0, seq_no = 0, done_cyc = -10, n_log = 0, gap_err = 0;
    bit         pend = 0, accepting = 1, first_conv = 1;
    logic [1:0] pend_ch = '0;
    logic [1:0] ch_log [16];
    logic [9:0] exp_reg [4];

    adc_scan_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
        .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [9:0] sample_of(input logic [1:0] ch, input int s);
        return 10'((int'(ch) * 197 + s * 31 + 5) % 1024);
    endfunction

    // Converter core: answers each start pulse after lat_cfg cycles.
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                conv_done = 1'b1;
                conv_data = sample_of(pend_ch, seq_no);
                if (accepting) exp_reg[pend_ch] = conv_data;
                seq_no++;
                pend = 0;
                done_cyc = cyc;
            end else cnt--;
        end
        if (conv_start) begin
            if (!first_conv && cyc != done_cyc + 1) gap_err++;
            first_conv = 0;
            if (n_log < 16) ch_log[n_log] = conv_ch;
            n_log++;
            pend = 1; pend_ch = conv_ch; cnt = lat_cfg;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    function automatic logic [15:0] ctrl_word(input logic st, input logic ie, input logic [1:0] md, input logic [1:0] cs);
        return {1'b0, ie, st, 7'd0, md, 2'b00, cs};
    endfunction

    task automatic check_data(input string req);
        logic [15:0] d;
        for (int k = 0; k < 4; k++) begin
            rd(3'(4 + k), d);
            chk(req, d, {6'd0, exp_reg[k]}, $sformatf("data reg ch%0d", k));
        end
    endtask

    task automatic run_pass(input logic [1:0] md, input logic [1:0] cs, input logic ie, input int lat);
        logic [15:0] d;
        int nexp, waited;
        lat_cfg = lat; accepting = 1; first_conv = 1; n_log = 0; gap_err = 0;
        wr(3'd0, ctrl_word(1'b1, ie, md, cs));
        waited = 0;
        do begin rd(3'd0, d); waited++; end while (!d[15] && waited < 300);
        nexp = (md == 2'b10) ? int'(cs) + 1 : 1;
        chk(md == 2'b10 ? "R3" : "R2", n_log, nexp, "conversions in pass");
        for (int k = 0; k < nexp && k < 16; k++)
            chk(md == 2'b10 ? "R3" : "R2", ch_log[k], (md == 2'b10) ? 2'(k) : cs, $sformatf("channel order slot %0d", k));
        chk("R4", gap_err, 0, "cycles between done and next start");
        chk("R6", d[15], 1'b1, "end flag after pass");
        chk("R6", d[13], 1'b0, "start bit after pass");
        chk("R10", {d[14], d[5:4], d[1:0]}, {ie, md, cs}, "field readback");
        chk("R7", irq, ie, "irq at pass end");
        check_data("R5");
        wr(3'd0, ctrl_word(1'b0, ie, md, cs));
        rd(3'd0, d);
        chk("R8", d[15], 1'b0, "end flag after write 0");
        chk("R7", irq, 1'b0, "irq after flag clear");
    endtask

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4; k++) exp_reg[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, d);
        chk("R1", d, 16'h0, "control word after reset");
        chk("R1", {irq, conv_start}, 2'b00, "irq/conv_start after reset");
        check_data("R1");
        // R10 readback without starting
        wr(3'd0, ctrl_word(1'b0, 1'b1, 2'b01, 2'd2));
        rd(3'd0, d);
        chk("R10", d, 16'h4012, "control word readback");
        chk("R9", n_log, 0, "no conversion without start");
        // directed passes
        run_pass(2'b00, 2'd2, 1'b1, 1);   // R2 single
        run_pass(2'b10, 2'd3, 1'b1, 1);   // R3 full multi, minimum latency
        run_pass(2'b10, 2'd0, 1'b0, 3);   // R3 multi with one channel, irq masked
        run_pass(2'b11, 2'd1, 1'b1, 2);   // R2 other code acts single
        run_pass(2'b01, 2'd3, 1'b0, 4);   // R2
        // R8 writing 1 to end flag does not set it
        wr(3'd0, 16'h8000);
        rd(3'd0, d);
        chk("R8", d[15], 1'b0, "end flag after write 1");
        // R9 abort mid-pass
        lat_cfg = 20; accepting = 1; first_conv = 1; n_log = 0;
        wr(3'd0, ctrl_word(1'b1, 1'b1, 2'b10, 2'd3));
        for (int w = 0; w < 50 && n_log == 0; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        accepting = 0;
        wr(3'd0, ctrl_word(1'b0, 1'b1, 2'b10, 2'd3));
        repeat (30) @(negedge clk);
        chk("R9", n_log, 1, "conversions after abort");
        rd(3'd0, d);
        chk("R9", d[15], 1'b0, "end flag after abort");
        chk("R9", irq, 1'b0, "irq after abort");
        check_data("R9");
        run_pass(2'b10, 2'd2, 1'b1, 2);
        chk("R9", ch_log[0], 2'd0, "restart from first channel");
        // seeded random passes
        for (int i = 0; i < 24; i++)
            run_pass(2'($urandom % 4), 2'($urandom % 4), 1'($urandom % 2), 1 + int'($urandom % 4));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule